// File: doc/BRIEF.md
# Tile Region Array Walker

This block walks the per-tile region array of a tile-based renderer and turns it into a stream of object-list requests. After a start pulse it reads the array from a word-addressed memory, beginning at a given word address. Each entry takes six consecutive words. The first word describes the tile: its column, its row and whether it closes the array. The next five words are list pointers, one for each list kind.

For every pointer that is not flagged empty, the walker offers one request on a valid/ready output. A request carries the tile column, the tile row, the list kind and the byte address of the object list. Empty pointers produce nothing. The walk ends after the entry whose tile word carries the final flag, and the block then gives a one-cycle completion pulse.

A typical full frame is 640×480 pixels cut into 32×32 tiles, which gives 20×15 entries. The walker does not depend on that count, because only the final flag stops it. Downstream logic parses the object lists, rasterizes and writes the framebuffer.

Top module: `tile_region_walker`

## Requirements
- R1: Out of reset, and until `start` is pulsed, `req_valid`, `done` and `mem_rd_en` are all 0.
- R2: A walk reads memory at word addresses `base_addr`, `base_addr+1`, … in strict ascending order, one read per word. Each entry is six words. Read data is taken exactly one cycle after `mem_rd_en`.
- R3: Within an entry, word 0 is the tile word and words 1 to 5 are list pointers. These pointers map in order to `req_list` codes 0 opaque, 1 opaque modifier, 2 translucent, 3 translucent modifier and 4 punch-through. Requests leave in that order.
- R4: `req_tile_y` comes from tile word bits 13:8 and `req_tile_x` from tile word bits 7:2. The other bits of the tile word, except bit 31, have no effect on any output.
- R5: A list pointer with bit 31 set is empty and produces no request. Every pointer with bit 31 clear produces exactly one request.
- R6: `req_addr` equals pointer bits 23:2 followed by two zero bits. This is a byte address. Pointer bits 30:24 and 1:0 have no effect.
- R7: The walk stops after the six words of the entry whose tile word has bit 31 set. No later word is read and no later request appears.
- R8: While `req_valid` is 1 and `req_ready` is 0, `req_valid` stays 1 and every request field stays unchanged.
- R9: `done` is 1 for exactly one cycle. When the final pointer of the last entry is non-empty, that cycle is the one right after that request is accepted.
- R10: If the first entry already carries the final flag, exactly six words are read and only that entry's requests are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a walk (accepted when idle) |
| base_addr | input | AW | Word address of the first entry |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory word address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Consumer accepts the request |
| req_tile_x | output | 6 | Tile column |
| req_tile_y | output | 6 | Tile row |
| req_list | output | 3 | List kind code (0 to 4) |
| req_addr | output | 24 | Object list byte address |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a stalled request that sits beside a stream of skipped pointers, combined with a final flag that must stop the reads. The bench writes a sentinel entry with live pointers right after the last entry, so any overrun shows up as extra reads or requests. It fills the reserved bits of every word with varied junk. It runs scenarios in which the consumer's ready signal is held high, toggles every cycle, or drops every third cycle. Varied empty masks then place stalls next to skipped pointers and at the final pointer of the array.

// File: rtl/tile_walk_pkg.sv
package tile_walk_pkg;
  localparam int unsigned ENTRY_WORDS = 6;
  localparam int unsigned LIST_KINDS  = ENTRY_WORDS - 1;
  localparam int unsigned IDX_W       = 6;
  localparam int unsigned LADDR_W     = 22;
  localparam int unsigned SLOT_W      = $clog2(ENTRY_WORDS);

  typedef enum logic [2:0] {
    LK_OPAQUE    = 3'd0,
    LK_OPAQ_MOD  = 3'd1,
    LK_TRANS     = 3'd2,
    LK_TRANS_MOD = 3'd3,
    LK_PUNCH     = 3'd4
  } list_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CATCH,
    ST_EMIT,
    ST_FIN
  } walk_state_e;

  typedef struct packed {
    logic             last;
    logic [IDX_W-1:0] ty;
    logic [IDX_W-1:0] tx;
  } tile_hdr_t;

  typedef struct packed {
    logic               empty;
    logic [LADDR_W-1:0] waddr;
  } list_ptr_t;
endpackage

// File: rtl/tile_walk_decode.sv
module tile_walk_decode
  import tile_walk_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic [DW-1:0] word,
  output tile_hdr_t     hdr,
  output list_ptr_t     ptr
);
  localparam int unsigned FLAG_BIT = DW - 1;
  localparam int unsigned X_LSB    = 2;
  localparam int unsigned Y_LSB    = 8;
  localparam int unsigned A_LSB    = 2;

  always_comb begin
    hdr.last  = word[FLAG_BIT];
    hdr.ty    = word[Y_LSB +: IDX_W];
    hdr.tx    = word[X_LSB +: IDX_W];
    ptr.empty = word[FLAG_BIT];
    ptr.waddr = word[A_LSB +: LADDR_W];
  end
endmodule

// File: rtl/tile_walk_addr.sv
module tile_walk_addr #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          inc,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load | inc;
    addr_d  = load ? load_val : addr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr_q == $past(load_val));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/tile_walk_ctrl.sv
module tile_walk_ctrl
  import tile_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  tile_hdr_t   hdr_in,
  input  list_ptr_t   ptr_in,
  input  logic        req_ready,
  output logic        addr_load,
  output logic        addr_inc,
  output logic        rd_en,
  output logic        req_valid,
  output tile_hdr_t   hdr_out,
  output list_ptr_t   ptr_out,
  output logic [2:0]  kind,
  output logic        done
);
  localparam logic [SLOT_W-1:0] SLOT_TILE = '0;
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(ENTRY_WORDS - 1);

  walk_state_e       st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  tile_hdr_t         hdr_q, hdr_d;
  list_ptr_t         ptr_q, ptr_d;
  logic              step;

  always_comb begin
    st_d      = st_q;
    slot_d    = slot_q;
    hdr_d     = hdr_q;
    ptr_d     = ptr_q;
    addr_load = 1'b0;
    addr_inc  = 1'b0;
    rd_en     = 1'b0;
    step      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          addr_load = 1'b1;
          slot_d    = SLOT_TILE;
          st_d      = ST_READ;
        end
      end
      ST_READ: begin
        rd_en = 1'b1;
        st_d  = ST_CATCH;
      end
      ST_CATCH: begin
        if (slot_q == SLOT_TILE) begin
          hdr_d    = hdr_in;
          slot_d   = slot_q + 1'b1;
          addr_inc = 1'b1;
          st_d     = ST_READ;
        end else if (ptr_in.empty) begin
          step = 1'b1;
        end else begin
          ptr_d = ptr_in;
          st_d  = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (req_ready) step = 1'b1;
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (step) begin
      if (slot_q == SLOT_LAST) begin
        if (hdr_q.last) begin
          st_d = ST_FIN;
        end else begin
          slot_d   = SLOT_TILE;
          addr_inc = 1'b1;
          st_d     = ST_READ;
        end
      end else begin
        slot_d   = slot_q + 1'b1;
        addr_inc = 1'b1;
        st_d     = ST_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      hdr_q  <= '0;
      ptr_q  <= '0;
    end else begin
      st_q   <= st_d;
      slot_q <= slot_d;
      hdr_q  <= hdr_d;
      ptr_q  <= ptr_d;
    end
  end

  assign req_valid = (st_q == ST_EMIT);
  assign done      = (st_q == ST_FIN);
  assign hdr_out   = hdr_q;
  assign ptr_out   = ptr_q;
  assign kind      = 3'(slot_q - 1'b1);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(ptr_q) && $stable(slot_q) && $stable(hdr_q)));
  p_kind_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (slot_q != SLOT_TILE && slot_q <= SLOT_LAST));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_stop_on_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> hdr_q.last);
  p_no_empty_emit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !ptr_q.empty);
endmodule

// File: rtl/tile_region_walker.sv
module tile_region_walker
  import tile_walk_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        base_addr,
  output logic                 mem_rd_en,
  output logic [AW-1:0]        mem_rd_addr,
  input  logic [DW-1:0]        mem_rd_data,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [IDX_W-1:0]     req_tile_x,
  output logic [IDX_W-1:0]     req_tile_y,
  output logic [2:0]           req_list,
  output logic [LADDR_W+1:0]   req_addr,
  output logic                 done
);
  tile_hdr_t hdr_dec, hdr_cur;
  list_ptr_t ptr_dec, ptr_cur;
  logic      a_load, a_inc;

  tile_walk_decode #(.DW(DW)) u_dec (
    .word (mem_rd_data),
    .hdr  (hdr_dec),
    .ptr  (ptr_dec)
  );

  tile_walk_addr #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (a_load),
    .inc      (a_inc),
    .load_val (base_addr),
    .addr     (mem_rd_addr)
  );

  tile_walk_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hdr_in    (hdr_dec),
    .ptr_in    (ptr_dec),
    .req_ready (req_ready),
    .addr_load (a_load),
    .addr_inc  (a_inc),
    .rd_en     (mem_rd_en),
    .req_valid (req_valid),
    .hdr_out   (hdr_cur),
    .ptr_out   (ptr_cur),
    .kind      (req_list),
    .done      (done)
  );

  assign req_tile_x = hdr_cur.tx;
  assign req_tile_y = hdr_cur.ty;
  assign req_addr   = {ptr_cur.waddr, 2'b00};

  p_idle_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_valid, mem_rd_en, done}));
endmodule

// File: tb/tb_tile_region_walker.sv
`timescale 1ns/1ps
module tb_tile_region_walker;
  localparam int AW = 16;

  logic        clk, rst_n, start;
  logic [15:0] base_addr;
  logic        mem_rd_en;
  logic [15:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic        req_valid, req_ready;
  logic [5:0]  req_tile_x, req_tile_y;
  logic [2:0]  req_list;
  logic [23:0] req_addr;
  logic        done;

  tile_region_walker #(.AW(AW), .DW(32)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_tile_x(req_tile_x),
    .req_tile_y(req_tile_y), .req_list(req_list), .req_addr(req_addr), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] mem [0:255];
  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];

  int checks = 0, fails = 0;
  logic [5:0]  ex_x [0:63];
  logic [5:0]  ex_y [0:63];
  logic [2:0]  ex_k [0:63];
  logic [23:0] ex_a [0:63];
  int n_exp;

  typedef struct packed {
    logic [15:0] base;
    logic [7:0]  n_ent;
    logic [7:0]  seed;
    logic [1:0]  rmode;
    logic        all_empty;
  } scen_t;

  localparam scen_t SCN [0:4] = '{
    '{16'd0,   8'd4, 8'd3,  2'd0, 1'b0},
    '{16'd40,  8'd7, 8'd11, 2'd1, 1'b0},
    '{16'd100, 8'd5, 8'd26, 2'd2, 1'b0},
    '{16'd10,  8'd8, 8'd40, 2'd2, 1'b0},
    '{16'd160, 8'd3, 8'd7,  2'd1, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fill(input logic [15:0] base, input int n, input logic [7:0] seed, input bit all_empty);
    n_exp = 0;
    for (int i = 0; i <= n; i++) begin
      logic [5:0]  x  = 6'(i * 5 + int'(seed));
      logic [5:0]  y  = 6'(i * 3 + int'(seed) / 2);
      logic        lst = (i == n - 1) || (i == n);
      logic [31:0] tw = {lst, 17'(int'(seed) * 97 + i * 13 + 1), y, x, 2'b10};
      mem[8'(int'(base) + 6 * i)] = tw;
      for (int k = 0; k < 5; k++) begin
        logic [21:0] a = 22'(int'(seed) * 1000 + i * 37 + k * 5 + 1);
        logic emp = all_empty || (((i + k + int'(seed)) % 3 == 0) && i < n - 1);
        if (i == n) emp = 1'b0;
        mem[8'(int'(base) + 6 * i + 1 + k)] = {emp, 7'(int'(seed) + k + 1), a, 2'b01};
        if (i < n && !emp) begin
          ex_x[n_exp] = x; ex_y[n_exp] = y; ex_k[n_exp] = 3'(k); ex_a[n_exp] = {a, 2'b00};
          n_exp++;
        end
      end
    end
  endtask

  task automatic run_walk(input logic [15:0] base, input int n, input int rmode, input bit timing);
    int cyc = 0, got = 0, reads = 0, last_acc = -10, done_cyc = -1;
    bit  hold_pend = 0;
    logic [5:0] hx, hy; logic [2:0] hk; logic [23:0] ha;
    @(negedge clk); base_addr = base; start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (done_cyc < 0 && cyc < 3000) begin
      if (hold_pend)
        chk(req_valid && req_tile_x == hx && req_tile_y == hy && req_list == hk && req_addr == ha,
            "R8", "stall hold", {8'(req_valid), req_addr}, {8'd1, ha});
      if (mem_rd_en) begin
        chk(mem_rd_addr == base + 16'(reads) && reads < 6 * n, "R2", "read address",
            32'(mem_rd_addr), 32'(base) + 32'(reads));
        reads++;
      end
      if (done) done_cyc = cyc;
      req_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? 1'(cyc % 2) : 1'(cyc % 3 != 0);
      hold_pend = req_valid && !req_ready;
      hx = req_tile_x; hy = req_tile_y; hk = req_list; ha = req_addr;
      if (req_valid && req_ready) begin
        if (got < n_exp) begin
          chk(req_tile_x == ex_x[got] && req_tile_y == ex_y[got], "R4", "tile x/y",
              {20'h0, req_tile_y, req_tile_x}, {20'h0, ex_y[got], ex_x[got]});
          chk(req_list == ex_k[got], "R3", "list kind", 32'(req_list), 32'(ex_k[got]));
          chk(req_addr == ex_a[got], "R6", "list address", 32'(req_addr), 32'(ex_a[got]));
        end else chk(1'b0, "R5", "extra request", 32'(got), 32'(n_exp));
        got++;
        last_acc = cyc;
      end
      @(negedge clk); cyc++;
    end
    if (done_cyc < 0) chk(1'b0, "R9", "watchdog: no done", 32'(cyc), 32'd0);
    chk(got == n_exp, "R5", "request count", 32'(got), 32'(n_exp));
    chk(reads == 6 * n, "R7", "words read", 32'(reads), 32'(6 * n));
    if (timing) chk(done_cyc == last_acc + 1, "R9", "done after last accept",
                    32'(done_cyc - last_acc), 32'd1);
    chk(!done, "R9", "done single cycle", 32'(done), 32'd0);
    repeat (4) begin
      if (req_valid || mem_rd_en) chk(1'b0, "R7", "activity after walk", {30'h0, req_valid, mem_rd_en}, 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; base_addr = '0; req_ready = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk(!req_valid && !done && !mem_rd_en, "R1", "idle after reset",
          {29'h0, req_valid, done, mem_rd_en}, 32'd0);
    end

    for (int s = 0; s < 5; s++) begin
      fill(SCN[s].base, int'(SCN[s].n_ent), SCN[s].seed, SCN[s].all_empty);
      run_walk(SCN[s].base, int'(SCN[s].n_ent), int'(SCN[s].rmode), 1'b1);
    end

    // R10: first entry already flagged final
    fill(16'd200, 1, 8'd5, 1'b0);
    run_walk(16'd200, 1, 2, 1'b1);
    chk(n_exp == 5, "R10", "single entry request total", 32'(n_exp), 32'd5);

    // R5: a lone entry with every pointer empty yields no request but still finishes
    fill(16'd220, 1, 8'd9, 1'b1);
    run_walk(16'd220, 1, 0, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule